// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the internal access address for one port of a synchronous memory. At every rising clock edge it captures an external address and three active-low controls: a counter clear, an address load strobe and a step enable. From them it forms the address that the memory uses during the clock cycle that follows.

The chosen address is also kept in a register, so that later cycles can either reuse it or step past it. The block has no inputs for chip select or byte lanes. The counter therefore clears, loads and steps even while the port it serves is idle.

`addr_out` is driven by a small decode and multiplexer that sits after the capture registers. It settles shortly after the sampling edge, so the memory can use it within the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After the synchronous active-high `rst`, `addr_out` is 0 and stays at 0 while all three controls are held high.
- R2: If `clr_n` is low at a rising edge, `addr_out` is 0 for the cycle that follows. This happens whatever `load_n`, `step_n` and `ext_addr` are.
- R3: If `load_n` is low and `clr_n` is high at a rising edge, `addr_out` equals the `ext_addr` sampled at that edge. `step_n` has no effect in this case.
- R4: If `clr_n` and `load_n` are high and `step_n` is low at a rising edge, `addr_out` becomes the previous `addr_out` plus one. The step is applied in that same cycle, with no wait cycle.
- R5: If all three controls are high at a rising edge, `addr_out` keeps its previous value.
- R6: Stepping from the largest address, 2^ADDR_W-1 (16383 for the default width), gives 0.
- R7: Controls and `ext_addr` are used only as sampled at rising edges. Changes between edges do not alter `addr_out`.
- R8: A clear costs no dead cycle. A step in the cycle right after a clear gives address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_addr | input | ADDR_W (14) | External address, taken when loading |
| clr_n | input | 1 | Active-low counter clear (highest priority) |
| load_n | input | 1 | Active-low load of `ext_addr` |
| step_n | input | 1 | Active-low step by one |
| addr_out | output | ADDR_W (14) | Address used for the current access |

## Verification
Each of the block's results is due in the cycle directly after the edge that samples its controls. There is one capture register in the path, and the selection after it is purely combinational.

The bench drives inputs on falling edges. It checks `addr_out` 1 ns after the next rising edge, against a model that applies the clear, load, step and hold rules to the sampled values. For R7, the bench changes the inputs again between two edges and checks that the output still holds the earlier result. A full step sweep through every address covers the wrap.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_STEP = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_ZERO = 2'd3
  } sel_e;

  // Priority: clear over load over step over hold.
  function automatic sel_e decode_sel(input logic clr_n, input logic load_n,
                                      input logic step_n);
    if (!clr_n)       return SEL_ZERO;
    else if (!load_n) return SEL_LOAD;
    else if (!step_n) return SEL_STEP;
    else              return SEL_HOLD;
  endfunction
endpackage

// File: rtl/bac_ctrl_capture.sv
module bac_ctrl_capture
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              step_n,
  output sel_e              sel_q,
  output logic [ADDR_W-1:0] ext_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_HOLD;
      ext_q <= '0;
    end else begin
      sel_q <= decode_sel(clr_n, load_n, step_n);
      ext_q <= ext_addr;
    end
  end
endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  sel_e              sel,
  input  logic [ADDR_W-1:0] ext,
  input  logic [ADDR_W-1:0] prev,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc;
  // Natural modulo-2^ADDR_W wrap.
  assign inc = prev + ONE;

  always_comb begin
    unique case (sel)
      SEL_ZERO: cur = '0;
      SEL_LOAD: cur = ext;
      SEL_STEP: cur = inc;
      default:  cur = prev;
    endcase
  end
endmodule

// File: rtl/bac_hold_reg.sv
module bac_hold_reg #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] addr_out
);
  sel_e              sel_q;
  logic [ADDR_W-1:0] ext_q;
  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] cur;

  bac_ctrl_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .clr_n(clr_n),
    .load_n(load_n), .step_n(step_n), .sel_q(sel_q), .ext_q(ext_q)
  );

  bac_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .sel(sel_q), .ext(ext_q), .prev(prev_q), .cur(cur)
  );

  bac_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .d(cur), .q(prev_q)
  );

  assign addr_out = cur;

  // R2: clear gives zero next cycle
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> addr_out == '0);

  // R3: load takes the sampled external address
  a_r3_load_ext: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> addr_out == $past(ext_addr));

  // R4 and R6: step adds one, wrapping
  a_r4_step_inc: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !step_n) |=>
      addr_out == ADDR_W'($past(addr_out) + 1'b1));

  // R5: idle controls keep the address
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && step_n) |=> $stable(addr_out));

  // R1: reset forces zero
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> addr_out == '0);
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 14;
  localparam int MAXA = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          clr_n = 1'b1, load_n = 1'b1, step_n = 1'b1;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  int model = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .clr_n(clr_n),
    .load_n(load_n), .step_n(step_n), .addr_out(addr_out)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(addr_out) != exp) begin
      errors++;
      $display("FAIL %s: addr_out=%0d expected=%0d", req, addr_out, exp);
    end
  endtask

  // Called at a falling edge; drives, waits for the sampling edge, checks 1 ns later.
  task automatic cyc(input logic c, input logic l, input logic s,
                     input int a, input string req);
    clr_n = c; load_n = l; step_n = s; ext_addr = AW'(a);
    @(posedge clk);
    if (!c)      model = 0;
    else if (!l) model = a & MAXA;
    else if (!s) model = (model + 1) & MAXA;
    #1 check(req, model);
    @(negedge clk);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: expected=finish actual=timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R1", 0);
    cyc(1, 1, 1, 77, "R1");
    cyc(1, 1, 1, 5, "R1");
    // R3 with step also low
    cyc(1, 0, 0, 1234, "R3");
    cyc(1, 1, 0, 0, "R4");
    cyc(1, 1, 0, 0, "R4");
    cyc(1, 1, 1, 999, "R5");
    cyc(1, 1, 1, 999, "R5");
    // R2 overrides load and step
    cyc(0, 0, 0, 4321, "R2");
    cyc(1, 1, 0, 4321, "R8");
    cyc(1, 1, 0, 0, "R8");
    cyc(1, 0, 1, 500, "R3");
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 1, 1, 0, "R2");
    // R7: inputs sampled only at edges
    cyc(1, 0, 1, 300, "R7");
    clr_n = 1'b0; load_n = 1'b0; ext_addr = AW'(7);
    #1 check("R7", 300);
    clr_n = 1'b1; load_n = 1'b1; step_n = 1'b1;
    #0.5 check("R7", 300);
    cyc(1, 1, 1, 0, "R7");
    // R6 wrap from the top address
    cyc(1, 0, 1, MAXA, "R6");
    cyc(1, 1, 0, 0, "R6");
    cyc(1, 1, 0, 0, "R6");
    // R4/R6 exhaustive step sweep over the whole space
    cyc(1, 0, 1, 0, "R3");
    for (int i = 0; i < (1 << AW); i++) cyc(1, 1, 0, 0, "R4");
    // mixed pseudo-random patterns
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1] | lfsr[2], lfsr[3] | lfsr[4], lfsr[5],
          int'(lfsr[15:2]), "R2R3R4R5_mix");
    end
    // R1: reset in the middle of activity
    clr_n = 1'b1; load_n = 1'b0; ext_addr = AW'(55);
    rst = 1'b1;
    @(posedge clk); #1 check("R1", 0);
    @(negedge clk);
    rst = 1'b0; model = 0;
    cyc(1, 1, 1, 55, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule